// File: doc/BRIEF.md
# Tag Frame Transmit Sequencer

This block drives the endless broadcast loop of a passive tag. Once reset is released it plays out frames one after another, one bit per bit-time strobe. A frame is an optional framing bit, then an identity field of 4 to 19 bytes fetched from a byte-wide memory, then an optional closing framing bit, then a quiet window of eight bit times. During that window the command receiver may act. The two framing bits always have opposite values. A single enable controls both of them, and a polarity bit chooses the value of the closing bit.

Bytes are fetched with a one-cycle read latency. Each byte is prefetched into a holding register while the previous byte shifts out, so the identity bits leave back to back. The framing-bit settings are also presented on separate outputs, so the command path can wrap its own reply words in the same pair. On a strobe, the command path can force the sequencer back to the start of a fresh frame.

Top module: `tag_frame_seq`

## Requirements
- R1: After reset `tx_valid` and `listen_active` are 0 and `mem_addr` is 0.
- R2: Each frame consists of the opening bit, the identity field, the closing bit and then the eight-bit-time listening window. Frames repeat with no idle strobes between them.
- R3: The identity field has `cfg_len_code + 4` bytes for codes 0 to 15. Any code of 16 or more gives 19 bytes.
- R4: Identity bytes are sent from memory address 0 upward. Within each byte, bit 7 goes first.
- R5: When `cfg_bracket_en` is 0, neither framing bit is sent.
- R6: The closing bit equals `cfg_stop_one` and the opening bit is its inverse.
- R7: `listen_active` is 1 after each of the eight window strobes and 0 after every strobe that sends a bit. No `tx_valid` occurs while it is 1.
- R8: A strobe with `restart_req` = 1 sends no bit and clears `listen_active`. The next strobe starts a new frame from address 0.
- R9: `restart_req` has no effect on a cycle without `bit_tick`.
- R10: `brk_en` follows `cfg_bracket_en`, `brk_stop` follows `cfg_stop_one`, and `brk_start` is the inverse of `brk_stop`.
- R11: The configuration is captured at the first strobe of a frame. Changes made later in that frame do not alter it.
- R12: Each sent bit appears on `tx_bit` with `tx_valid` = 1 for exactly the one cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-cycle bit-time strobe, at least 4 cycles apart |
| restart_req | input | 1 | Restart request from command path, used on strobes |
| cfg_bracket_en | input | 1 | Enables the opening and closing framing bits |
| cfg_stop_one | input | 1 | Value of the closing framing bit |
| cfg_len_code | input | 5 | Identity length code |
| mem_addr | output | 5 | Byte address to the identity memory |
| mem_rd | output | 1 | Read request; data is expected one cycle later |
| mem_rdata | input | 8 | Read data |
| tx_bit | output | 1 | Serial bit out |
| tx_valid | output | 1 | Marks the cycle carrying a new bit |
| listen_active | output | 1 | Listening window is open |
| brk_en | output | 1 | Framing pair enabled, for reply words |
| brk_start | output | 1 | Opening framing bit value |
| brk_stop | output | 1 | Closing framing bit value |

## Verification
The bench goes after the length boundaries: code 0, code 15 and clamped codes above 15. A design that mishandled these would send a field one byte short or long, or would wrap a large code into a short field. With the framing bits disabled, the first strobe of a frame must fetch the first byte directly; a design that got this wrong would emit a stale or shifted first byte. Restarts are issued mid-field and mid-window, and restart requests are raised between strobes. A faulty design would either resume at the wrong address or would react to the request between strobes. Configuration is changed in the middle of frames, which exposes a design that fails to latch it at frame start.

// File: rtl/tfs_pkg.sv
// Shared types for the tag frame sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package tfs_pkg;

    // Frame position held between strobes
    typedef enum logic [1:0] {
        PH_SOF    = 2'd0,
        PH_ID     = 2'd1,
        PH_EOF    = 2'd2,
        PH_LISTEN = 2'd3
    } tfs_phase_e;

    // Work done on the current strobe
    typedef enum logic [2:0] {
        ACT_NONE    = 3'd0,
        ACT_RESTART = 3'd1,
        ACT_START   = 3'd2,
        ACT_ID      = 3'd3,
        ACT_STOP    = 3'd4,
        ACT_LISTEN  = 3'd5
    } tfs_act_e;

endpackage

// File: rtl/tfs_cfg_decode.sv
// Turns the raw configuration inputs into an identity byte count and
// the framing bit pair.
// Assumes: MIN_ID_BYTES <= MAX_ID_BYTES and both fit in CNT_W bits.
module tfs_cfg_decode #(
    parameter int LEN_CODE_W   = 5,
    parameter int MIN_ID_BYTES = 4,
    parameter int MAX_ID_BYTES = 19,
    parameter int CNT_W        = 5
) (
    input  logic [LEN_CODE_W-1:0] cfg_len_code,
    input  logic                  cfg_bracket_en,
    input  logic                  cfg_stop_one,
    output logic [CNT_W-1:0]      id_bytes,
    output logic                  pair_en,
    output logic                  pair_start,
    output logic                  pair_stop
);
    localparam int CODE_MAX = MAX_ID_BYTES - MIN_ID_BYTES;

    // Length code to byte count, saturating at the largest field
    always_comb begin
        if (int'(cfg_len_code) > CODE_MAX)
            id_bytes = CNT_W'(MAX_ID_BYTES);
        else
            id_bytes = CNT_W'(int'(cfg_len_code) + MIN_ID_BYTES);
    end

    // Framing pair: closing bit as configured, opening bit its inverse
    always_comb begin
        pair_en    = cfg_bracket_en;
        pair_stop  = cfg_stop_one;
        pair_start = ~cfg_stop_one;
    end
endmodule

// File: rtl/tfs_phase_ctrl.sv
// Frame controller: decides on every strobe whether to send a framing
// bit, an identity bit or a window slot, or to restart, and keeps the
// bit, byte and window counters. Configuration is latched on the
// first strobe of a frame.
// Assumes: bit_tick is a single-cycle pulse; live_bytes >= 1.
module tfs_phase_ctrl
    import tfs_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int CNT_W       = 5,
    parameter int LISTEN_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             restart_req,
    input  logic             live_en,
    input  logic             live_stop,
    input  logic [CNT_W-1:0] live_bytes,
    output tfs_act_e         act,
    output logic             cur_stop,
    output logic             rewind,
    output logic             take_byte,
    output logic             shift_bit
);
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int LCNT_W = $clog2(LISTEN_BITS + 1);

    tfs_phase_e        phase_q;
    logic [BIT_W-1:0]  bit_idx_q;
    logic [CNT_W-1:0]  byte_cnt_q;
    logic [LCNT_W-1:0] lcnt_q;
    logic              lat_en_q;
    logic              lat_stop_q;
    logic [CNT_W-1:0]  lat_bytes_q;

    logic             sof;
    logic             cur_en;
    logic [CNT_W-1:0] cur_bytes;
    logic             last_bit;
    logic             last_byte;
    logic             last_listen;

    // Effective configuration: live at frame start, latched afterwards
    always_comb begin
        sof       = (phase_q == PH_SOF);
        cur_en    = sof ? live_en    : lat_en_q;
        cur_stop  = sof ? live_stop  : lat_stop_q;
        cur_bytes = sof ? live_bytes : lat_bytes_q;
    end

    // Classify the current strobe
    always_comb begin
        act = ACT_NONE;
        if (bit_tick) begin
            if (restart_req) begin
                act = ACT_RESTART;
            end else begin
                case (phase_q)
                    PH_SOF:  act = cur_en ? ACT_START : ACT_ID;
                    PH_ID:   act = ACT_ID;
                    PH_EOF:  act = ACT_STOP;
                    default: act = ACT_LISTEN;
                endcase
            end
        end
    end

    // Counter end flags and shifter controls
    always_comb begin
        last_bit    = (bit_idx_q == BIT_W'(BYTE_W - 1));
        last_byte   = (byte_cnt_q == cur_bytes - CNT_W'(1));
        last_listen = (lcnt_q == LCNT_W'(LISTEN_BITS - 1));
        take_byte   = (act == ACT_ID) && (bit_idx_q == '0);
        shift_bit   = (act == ACT_ID) && (bit_idx_q != '0);
        rewind      = (act == ACT_RESTART) || ((act == ACT_LISTEN) && last_listen);
    end

    // Advance frame position and counters on each strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_SOF;
            bit_idx_q   <= '0;
            byte_cnt_q  <= '0;
            lcnt_q      <= '0;
            lat_en_q    <= 1'b0;
            lat_stop_q  <= 1'b0;
            lat_bytes_q <= '0;
        end else begin
            if (sof && (act == ACT_START || act == ACT_ID)) begin
                lat_en_q    <= live_en;
                lat_stop_q  <= live_stop;
                lat_bytes_q <= live_bytes;
            end
            case (act)
                ACT_RESTART: begin
                    phase_q    <= PH_SOF;
                    bit_idx_q  <= '0;
                    byte_cnt_q <= '0;
                    lcnt_q     <= '0;
                end
                ACT_START: begin
                    phase_q <= PH_ID;
                end
                ACT_ID: begin
                    phase_q <= PH_ID;
                    if (last_bit) begin
                        bit_idx_q <= '0;
                        if (last_byte) begin
                            byte_cnt_q <= '0;
                            phase_q    <= cur_en ? PH_EOF : PH_LISTEN;
                        end else begin
                            byte_cnt_q <= byte_cnt_q + CNT_W'(1);
                        end
                    end else begin
                        bit_idx_q <= bit_idx_q + BIT_W'(1);
                    end
                end
                ACT_STOP: begin
                    phase_q <= PH_LISTEN;
                end
                ACT_LISTEN: begin
                    if (last_listen) begin
                        lcnt_q  <= '0;
                        phase_q <= PH_SOF;
                    end else begin
                        lcnt_q <= lcnt_q + LCNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tfs_id_shifter.sv
// Identity byte path: issues byte reads, captures the returned byte
// into a holding register, and shifts the current byte out MSB first.
// Assumes: read data is valid the cycle after mem_rd; at least 3 cycles
// pass between a rewind or take and the next take.
module tfs_id_shifter #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rewind,
    input  logic              take_byte,
    input  logic              shift_bit,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              id_bit
);
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;
    logic              pend_q;
    logic [BYTE_W-1:0] hold_q;
    logic [BYTE_W-1:0] sh_q;

    // Address and read request: restart at 0, step on each byte taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rd_q   <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            rd_q   <= rewind | take_byte;
            pend_q <= rd_q;
            if (rewind)
                addr_q <= '0;
            else if (take_byte)
                addr_q <= addr_q + ADDR_W'(1);
        end
    end

    // Capture prefetched byte and run the output shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            sh_q   <= '0;
        end else begin
            if (pend_q)
                hold_q <= mem_rdata;
            if (take_byte)
                sh_q <= {hold_q[BYTE_W-2:0], 1'b0};
            else if (shift_bit)
                sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
        end
    end

    // Bit on offer: fresh byte MSB on a take, else shifter MSB
    always_comb begin
        id_bit   = take_byte ? hold_q[BYTE_W-1] : sh_q[BYTE_W-1];
        mem_addr = addr_q;
        mem_rd   = rd_q;
    end
endmodule

// File: rtl/tag_frame_seq.sv
// Top of the tag frame sequencer: ties the configuration decode, the
// frame controller and the identity byte path together and registers
// the serial outputs.
// Assumes: bit_tick pulses are at least 4 cycles apart and the first
// one comes at least 4 cycles after reset is released.
module tag_frame_seq
    import tfs_pkg::*;
#(
    parameter int LEN_CODE_W   = 5,
    parameter int MIN_ID_BYTES = 4,
    parameter int MAX_ID_BYTES = 19,
    parameter int BYTE_W       = 8,
    parameter int ADDR_W       = 5,
    parameter int LISTEN_BITS  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_tick,
    input  logic                  restart_req,
    input  logic                  cfg_bracket_en,
    input  logic                  cfg_stop_one,
    input  logic [LEN_CODE_W-1:0] cfg_len_code,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_rd,
    input  logic [BYTE_W-1:0]     mem_rdata,
    output logic                  tx_bit,
    output logic                  tx_valid,
    output logic                  listen_active,
    output logic                  brk_en,
    output logic                  brk_start,
    output logic                  brk_stop
);
    localparam int CNT_W = $clog2(MAX_ID_BYTES + 1);

    logic [CNT_W-1:0] id_bytes;
    tfs_act_e         act;
    logic             cur_stop;
    logic             rewind;
    logic             take_byte;
    logic             shift_bit;
    logic             id_bit;

    tfs_cfg_decode #(
        .LEN_CODE_W  (LEN_CODE_W),
        .MIN_ID_BYTES(MIN_ID_BYTES),
        .MAX_ID_BYTES(MAX_ID_BYTES),
        .CNT_W       (CNT_W)
    ) dec_i (
        .cfg_len_code  (cfg_len_code),
        .cfg_bracket_en(cfg_bracket_en),
        .cfg_stop_one  (cfg_stop_one),
        .id_bytes      (id_bytes),
        .pair_en       (brk_en),
        .pair_start    (brk_start),
        .pair_stop     (brk_stop)
    );

    tfs_phase_ctrl #(
        .BYTE_W     (BYTE_W),
        .CNT_W      (CNT_W),
        .LISTEN_BITS(LISTEN_BITS)
    ) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .restart_req(restart_req),
        .live_en    (brk_en),
        .live_stop  (brk_stop),
        .live_bytes (id_bytes),
        .act        (act),
        .cur_stop   (cur_stop),
        .rewind     (rewind),
        .take_byte  (take_byte),
        .shift_bit  (shift_bit)
    );

    tfs_id_shifter #(
        .BYTE_W(BYTE_W),
        .ADDR_W(ADDR_W)
    ) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rewind   (rewind),
        .take_byte(take_byte),
        .shift_bit(shift_bit),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .mem_rd   (mem_rd),
        .id_bit   (id_bit)
    );

    // Register the outgoing bit, its strobe and the window flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit        <= 1'b0;
            tx_valid      <= 1'b0;
            listen_active <= 1'b0;
        end else begin
            tx_valid <= (act == ACT_START) || (act == ACT_ID) || (act == ACT_STOP);
            if (bit_tick)
                listen_active <= (act == ACT_LISTEN);
            case (act)
                ACT_START: tx_bit <= ~cur_stop;
                ACT_STOP:  tx_bit <= cur_stop;
                ACT_ID:    tx_bit <= id_bit;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/tag_frame_seq_chk.sv
// Property checker for tag_frame_seq, attached by bind.
// Assumes: the same parameters as the bound instance.
module tag_frame_seq_chk #(
    parameter int MAX_ID_BYTES = 19,
    parameter int ADDR_W       = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bit_tick,
    input logic              restart_req,
    input logic              tx_valid,
    input logic              listen_active,
    input logic              brk_en,
    input logic              brk_start,
    input logic              brk_stop,
    input logic [ADDR_W-1:0] mem_addr
);
    // R12: a bit only appears right after a strobe
    a_r12_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(bit_tick));

    // R7: no bit is sent while the window is open
    a_r7_quiet_window: assert property (@(posedge clk) disable iff (!rst_n)
        listen_active |-> !tx_valid);

    // R6: the framing pair is always complementary
    a_r6_pair_inverse: assert property (@(posedge clk) disable iff (!rst_n)
        brk_en |-> (brk_start != brk_stop));

    // R8: a restart strobe sends nothing and closes the window
    a_r8_restart_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && restart_req) |=> (!tx_valid && !listen_active));

    // R9: the window flag only moves on strobes
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(listen_active));

    // R3: the byte address never runs past the longest field
    a_r3_addr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mem_addr) <= MAX_ID_BYTES);
endmodule

bind tag_frame_seq tag_frame_seq_chk #(
    .MAX_ID_BYTES(MAX_ID_BYTES),
    .ADDR_W      (ADDR_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .restart_req  (restart_req),
    .tx_valid     (tx_valid),
    .listen_active(listen_active),
    .brk_en       (brk_en),
    .brk_start    (brk_start),
    .brk_stop     (brk_stop),
    .mem_addr     (mem_addr)
);

// File: tb/tag_frame_seq_tb_top.sv
module tag_frame_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       restart_req = 1'b0;
    logic       cfg_bracket_en = 1'b0;
    logic       cfg_stop_one = 1'b0;
    logic [4:0] cfg_len_code = '0;
    logic [4:0] mem_addr;
    logic       mem_rd;
    logic [7:0] mem_rdata = '0;
    logic       tx_bit, tx_valid, listen_active;
    logic       brk_en, brk_start, brk_stop;

    logic [7:0] mem [0:31];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_frame_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .restart_req(restart_req),
        .cfg_bracket_en(cfg_bracket_en), .cfg_stop_one(cfg_stop_one),
        .cfg_len_code(cfg_len_code), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata), .tx_bit(tx_bit), .tx_valid(tx_valid),
        .listen_active(listen_active), .brk_en(brk_en), .brk_start(brk_start),
        .brk_stop(brk_stop)
    );

    // Identity memory model: one cycle read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_bytes(logic [4:0] code);
        return (code > 5'd15) ? 19 : int'(code) + 4;
    endfunction

    // Expected {valid, bit, listen} for slot s of a frame
    function automatic logic [2:0] exp_slot(logic en, logic stop, int nb, int s);
        int k = s;
        if (en) begin
            if (k == 0) return {1'b1, ~stop, 1'b0};
            k--;
        end
        if (k < nb * 8) return {1'b1, mem[k / 8][7 - (k % 8)], 1'b0};
        k -= nb * 8;
        if (en) begin
            if (k == 0) return {1'b1, stop, 1'b0};
            k--;
        end
        return 3'b001;
    endfunction

    // One strobe, 4 cycles; ghost raises restart_req off-strobe (R9)
    task automatic do_tick(input logic rr, input logic ghost,
                           output logic v, output logic b, output logic l);
        @(negedge clk); bit_tick = 1'b1; restart_req = rr;
        @(negedge clk); bit_tick = 1'b0; restart_req = ghost;
        v = tx_valid; b = tx_bit; l = listen_active;
        @(negedge clk); restart_req = 1'b0;
        @(negedge clk);
    endtask

    // Run and check one whole frame starting at its first strobe
    task automatic run_frame(input logic en, input logic stop, input logic [4:0] code,
                             input logic mid_cfg, input logic ghost, input string tag);
        int nb = exp_bytes(code);
        int total = (en ? 2 : 0) + nb * 8 + 8;
        logic v, b, l;
        logic [2:0] e;
        cfg_bracket_en = en; cfg_stop_one = stop; cfg_len_code = code;
        @(negedge clk);
        chk("R10", {brk_en, brk_start, brk_stop}, {en, ~stop, stop}, "pair outputs");
        for (int s = 0; s < total; s++) begin
            do_tick(1'b0, ghost, v, b, l);
            if (s == 0 && mid_cfg) begin
                cfg_bracket_en = $urandom_range(1, 0);
                cfg_stop_one   = $urandom_range(1, 0);
                cfg_len_code   = 5'($urandom_range(31, 0));
            end
            e = exp_slot(en, stop, nb, s);
            chk("R2", v, e[2], $sformatf("%s valid slot %0d", tag, s));
            if (e[2]) chk(tag, b, e[1], $sformatf("bit slot %0d", s));
            chk("R7", l, e[0], $sformatf("%s window slot %0d", tag, s));
        end
    endtask

    // Send a few strobes of a frame, then restart on a strobe (R8)
    task automatic cut_frame(input int n);
        logic v, b, l;
        cfg_bracket_en = 1'b1; cfg_stop_one = 1'b1; cfg_len_code = 5'd0;
        for (int i = 0; i < n; i++) do_tick(1'b0, 1'b0, v, b, l);
        do_tick(1'b1, 1'b0, v, b, l);
        chk("R8", {v, l}, 2'b00, "restart strobe output");
    endtask

    initial begin
        void'($urandom(32'h5EED_0A11));
        for (int i = 0; i < 32; i++) mem[i] = 8'($urandom);
        mem[0] = 8'hA5; mem[18] = 8'h3C;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {tx_valid, listen_active}, 2'b00, "outputs after reset");
        chk("R1", mem_addr, 5'd0, "address after reset");
        repeat (4) @(negedge clk);

        // Directed boundaries
        run_frame(1'b1, 1'b1, 5'd0,  1'b0, 1'b0, "R4");   // shortest, stop=1
        run_frame(1'b1, 1'b0, 5'd15, 1'b0, 1'b0, "R6");   // longest, stop=0
        run_frame(1'b0, 1'b0, 5'd31, 1'b0, 1'b0, "R3");   // clamped, no pair
        run_frame(1'b0, 1'b1, 5'd2,  1'b0, 1'b0, "R5");   // pair disabled
        run_frame(1'b1, 1'b1, 5'd16, 1'b1, 1'b0, "R11");  // cfg moved mid-frame
        run_frame(1'b1, 1'b0, 5'd5,  1'b0, 1'b1, "R9");   // off-strobe requests

        // Restart mid-field, then mid-window
        cut_frame(13);
        run_frame(1'b1, 1'b0, 5'd1, 1'b0, 1'b0, "R8");
        cut_frame(1 + 32 + 1 + 3);
        run_frame(1'b0, 1'b0, 5'd3, 1'b0, 1'b0, "R8");

        // Constrained random frames
        for (int f = 0; f < 10; f++) begin
            run_frame(1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                      5'($urandom_range(31, 0)), 1'($urandom_range(1, 0)),
                      1'($urandom_range(1, 0)), "R12");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule